// File: doc/BRIEF.md
# Dataway Cycle Sequencer with No-Q Retry

This block turns one decoded crate command into dataway activity and a reply. A command carries a station number, a sub-address, a function code, 24 bits of write data and, for the serial requester, a retry flag and a parity-error flag. The sequencer sorts the command into one of four kinds: an ordinary module access, a controller command at station 28, a controller command at station 30, or a command it does not recognize. Module accesses and the crate-clear command arbitrate for the dataway first. Then a busy strobe of fixed length runs, and Q, X and read data are captured at the end of it. The crate-initialize command skips arbitration altogether.

Two requesters share the block: a serial command path and a byte-wide local port. The serial path wins when both ask at once. Each requester holds its request until a done pulse is raised with its own source flag. At the same moment the result word and the status word become valid, and they stay unchanged until the next done pulse. Controller commands at station 30 read the slot request word or drive the crate inhibit line. The crate monitor word is an input, read back by a station-28 command.

Top module: `dataway_seq`

## Requirements
- R1: A command with station 1 to 24 is a module access. It raises `bus_req`, waits for `bus_gnt`, then runs one busy strobe. Any station other than 1 to 24, 28 or 30 runs no strobe and returns Q=0, X=0 and result 0.
- R2: Station 28 with function 0 and sub-address 0 returns `mon_word` as the result, with Q=0 and X=1, and runs no strobe.
- R3: Station 28 with function 26 and sub-address 8 runs one strobe with `dw_z` high. `bus_req` stays low and `bus_gnt` is not needed. It returns Q=0, X=1 and result 0.
- R4: Station 28 with function 26 and sub-address 9 arbitrates and then runs one strobe with `dw_c` high. It returns Q=0, X=1 and result 0.
- R5: Station 30 with function 0 and sub-address 0 returns `lam_word`, where bit k-1 is the request from slot k. It returns Q=1, X=1 and runs no strobe.
- R6: `inhibit` is 1 after reset. Station 30 with function 24 and sub-address 9 clears it, and station 30 with function 26 and sub-address 9 sets it. Both return Q=0 and X=1.
- R7: Any other function or sub-address at station 28 or 30 runs no strobe and returns Q=0 and X=0.
- R8: A strobe holds `dw_busy` high for BUSY_CYC cycles. During the strobe, `dw_n`, `dw_a`, `dw_f` and `dw_wdata` carry the command. `dw_q`, `dw_x` and `dw_rdata` are sampled in the last strobe cycle, and a module access returns the sampled `dw_rdata` as its result.
- R9: A serial access with `ser_retry`=1 that samples Q=0 runs up to MAX_RETRY more strobes. Before each extra strobe there is a gap of RETRY_GAP cycles, during which `bus_req` stays high. The reported Q and X are those of the last strobe.
- R10: If `bus_gnt` does not arrive within ARB_TIMEOUT cycles of `bus_req`, no strobe runs. The status word then carries the timeout bit with Q=0 and X=0.
- R11: When both requests are present in the same idle cycle, the serial command is served first. The local command is served after it, and it never retries.
- R12: A serial command with `ser_perr`=1 runs no strobe. Its status word carries the parity bit, with Q=0 and X=0.
- R13: `done` is a single-cycle pulse. `status` bit 0 is Q, bit 1 is X, bit 2 is bus timeout, bit 3 is parity error and bit 4 is 1 (reply valid). `done_par` is 1 when the local port issued the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_req | input | 1 | Serial command present, held until its done |
| ser_n | input | 5 | Serial station number |
| ser_a | input | 4 | Serial sub-address |
| ser_f | input | 5 | Serial function code |
| ser_wdata | input | 24 | Serial write data |
| ser_retry | input | 1 | Retry on missing Q |
| ser_perr | input | 1 | Serial command arrived with a parity error |
| par_req | input | 1 | Local-port command present, held until its done |
| par_n | input | 5 | Local station number |
| par_a | input | 4 | Local sub-address |
| par_f | input | 5 | Local function code |
| par_wdata | input | 24 | Local write data |
| bus_req | output | 1 | Dataway request to the arbiter |
| bus_gnt | input | 1 | Dataway grant from the arbiter |
| dw_busy | output | 1 | Dataway busy strobe |
| dw_z | output | 1 | Initialize qualifier during the strobe |
| dw_c | output | 1 | Clear qualifier during the strobe |
| dw_n | output | 5 | Station driven to the dataway |
| dw_a | output | 4 | Sub-address driven to the dataway |
| dw_f | output | 5 | Function driven to the dataway |
| dw_wdata | output | 24 | Write data driven to the dataway |
| dw_rdata | input | 24 | Read data from the dataway |
| dw_q | input | 1 | Module Q response |
| dw_x | input | 1 | Module X response |
| lam_word | input | 24 | Slot request lines |
| mon_word | input | 24 | Packed crate monitor value |
| inhibit | output | 1 | Crate inhibit level |
| done | output | 1 | Reply valid pulse |
| done_par | output | 1 | Reply belongs to the local port |
| result | output | 24 | Reply data word |
| status | output | 5 | Reply status word |

## Verification
The bench builds the block with BUSY_CYC=3, RETRY_GAP=4, ARB_TIMEOUT=6 and MAX_RETRY=3. These values are much smaller than the real timings, which are microseconds at the sequencing clock. With them, a full chain of four strobes and three gaps fits in a few dozen cycles, so the run covers both a retry sequence that ends with Q found and one that uses up every retry. The short timeout makes the no-grant path cheap to reach, and the bench counts its exact number of request cycles. The modelled module answers Q only from a chosen attempt number onwards, which places the Q response at each step of the retry sequence.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_STROBE,
        ST_GAP,
        ST_FINISH
    } seq_st_e;

    typedef enum logic [2:0] {
        ACT_ACCESS,
        ACT_MON,
        ACT_Z,
        ACT_C,
        ACT_LAM,
        ACT_INH_CLR,
        ACT_INH_SET,
        ACT_NONE
    } seq_act_e;

    localparam int STAT_W   = 5;
    localparam int STAT_Q   = 0;
    localparam int STAT_X   = 1;
    localparam int STAT_TMO = 2;
    localparam int STAT_PAR = 3;
    localparam int STAT_VLD = 4;

endpackage

// File: rtl/ccs_classify.sv
module ccs_classify
    import ccs_pkg::*;
#(
    parameter int NW        = 5,
    parameter int AW        = 4,
    parameter int FW        = 5,
    parameter int LAST_SLOT = 24,
    parameter int CTL_LOW   = 28,
    parameter int CTL_HIGH  = 30
) (
    input  logic [NW-1:0] n,
    input  logic [AW-1:0] a,
    input  logic [FW-1:0] f,
    output seq_act_e      act
);
    localparam logic [NW-1:0] N_LAST = NW'(LAST_SLOT);
    localparam logic [NW-1:0] N_LOW  = NW'(CTL_LOW);
    localparam logic [NW-1:0] N_HIGH = NW'(CTL_HIGH);

    logic is_f0a0;
    logic is_f26;
    logic is_f24;

    always_comb begin
        is_f0a0 = (f == '0) && (a == '0);
        is_f26  = (f == FW'(26));
        is_f24  = (f == FW'(24));
        act     = ACT_NONE;
        if (n != '0 && n <= N_LAST) begin
            act = ACT_ACCESS;
        end else if (n == N_LOW) begin
            if (is_f0a0)                         act = ACT_MON;
            else if (is_f26 && a == AW'(8))      act = ACT_Z;
            else if (is_f26 && a == AW'(9))      act = ACT_C;
        end else if (n == N_HIGH) begin
            if (is_f0a0)                         act = ACT_LAM;
            else if (is_f24 && a == AW'(9))      act = ACT_INH_CLR;
            else if (is_f26 && a == AW'(9))      act = ACT_INH_SET;
        end
    end

endmodule

// File: rtl/ccs_timer.sv
module ccs_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                    cnt_d = load_val;
        else if (dec && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(1));

endmodule

// File: rtl/dataway_seq.sv
module dataway_seq
    import ccs_pkg::*;
#(
    parameter int DW          = 24,
    parameter int NW          = 5,
    parameter int AW          = 4,
    parameter int FW          = 5,
    parameter int BUSY_CYC    = 5,
    parameter int RETRY_GAP   = 50,
    parameter int ARB_TIMEOUT = 255,
    parameter int MAX_RETRY   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_req,
    input  logic [NW-1:0]     ser_n,
    input  logic [AW-1:0]     ser_a,
    input  logic [FW-1:0]     ser_f,
    input  logic [DW-1:0]     ser_wdata,
    input  logic              ser_retry,
    input  logic              ser_perr,
    input  logic              par_req,
    input  logic [NW-1:0]     par_n,
    input  logic [AW-1:0]     par_a,
    input  logic [FW-1:0]     par_f,
    input  logic [DW-1:0]     par_wdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              dw_busy,
    output logic              dw_z,
    output logic              dw_c,
    output logic [NW-1:0]     dw_n,
    output logic [AW-1:0]     dw_a,
    output logic [FW-1:0]     dw_f,
    output logic [DW-1:0]     dw_wdata,
    input  logic [DW-1:0]     dw_rdata,
    input  logic              dw_q,
    input  logic              dw_x,
    input  logic [DW-1:0]     lam_word,
    input  logic [DW-1:0]     mon_word,
    output logic              inhibit,
    output logic              done,
    output logic              done_par,
    output logic [DW-1:0]     result,
    output logic [STAT_W-1:0] status
);
    localparam int TMAX_A = (BUSY_CYC > RETRY_GAP) ? BUSY_CYC : RETRY_GAP;
    localparam int TMAX   = (TMAX_A > ARB_TIMEOUT) ? TMAX_A : ARB_TIMEOUT;
    localparam int CW     = $clog2(TMAX + 1);
    localparam int RW     = $clog2(MAX_RETRY + 1) < 1 ? 1 : $clog2(MAX_RETRY + 1);

    typedef struct packed {
        seq_st_e           st;
        seq_act_e          act;
        logic              par;
        logic              retry;
        logic [RW-1:0]     left;
        logic [NW-1:0]     n;
        logic [AW-1:0]     a;
        logic [FW-1:0]     f;
        logic [DW-1:0]     wdata;
        logic              q;
        logic              x;
        logic              tmo;
        logic              perr;
        logic [DW-1:0]     res;
        logic              inh;
        logic              done;
        logic              done_par;
        logic [DW-1:0]     out_res;
        logic [STAT_W-1:0] out_stat;
    } seq_regs_s;

    seq_regs_s r_d, r_q;

    logic [NW-1:0] sel_n;
    logic [AW-1:0] sel_a;
    logic [FW-1:0] sel_f;
    logic [DW-1:0] sel_wdata;
    seq_act_e      sel_act;

    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_dec;
    logic          t_last;

    assign sel_n     = ser_req ? ser_n     : par_n;
    assign sel_a     = ser_req ? ser_a     : par_a;
    assign sel_f     = ser_req ? ser_f     : par_f;
    assign sel_wdata = ser_req ? ser_wdata : par_wdata;

    ccs_classify #(
        .NW (NW),
        .AW (AW),
        .FW (FW)
    ) u_cls (
        .n   (sel_n),
        .a   (sel_a),
        .f   (sel_f),
        .act (sel_act)
    );

    ccs_timer #(
        .CW (CW)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .dec      (t_dec),
        .last     (t_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        t_load   = 1'b0;
        t_val    = '0;
        t_dec    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (ser_req || par_req) begin
                    r_d.par   = !ser_req;
                    r_d.retry = ser_req && ser_retry;
                    r_d.left  = RW'(MAX_RETRY);
                    r_d.n     = sel_n;
                    r_d.a     = sel_a;
                    r_d.f     = sel_f;
                    r_d.wdata = sel_wdata;
                    r_d.act   = sel_act;
                    r_d.q     = 1'b0;
                    r_d.x     = 1'b0;
                    r_d.tmo   = 1'b0;
                    r_d.perr  = 1'b0;
                    r_d.res   = '0;
                    r_d.st    = ST_FINISH;
                    if (ser_req && ser_perr) begin
                        r_d.perr = 1'b1;
                        r_d.act  = ACT_NONE;
                    end else begin
                        unique case (sel_act)
                            ACT_ACCESS, ACT_C: begin
                                r_d.st = ST_ARB;
                                t_load = 1'b1;
                                t_val  = CW'(ARB_TIMEOUT);
                            end
                            ACT_Z: begin
                                r_d.st = ST_STROBE;
                                t_load = 1'b1;
                                t_val  = CW'(BUSY_CYC);
                            end
                            ACT_MON: begin
                                r_d.res = mon_word;
                                r_d.x   = 1'b1;
                            end
                            ACT_LAM: begin
                                r_d.res = lam_word;
                                r_d.q   = 1'b1;
                                r_d.x   = 1'b1;
                            end
                            ACT_INH_CLR: begin
                                r_d.inh = 1'b0;
                                r_d.x   = 1'b1;
                            end
                            ACT_INH_SET: begin
                                r_d.inh = 1'b1;
                                r_d.x   = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
            ST_ARB: begin
                if (bus_gnt) begin
                    r_d.st = ST_STROBE;
                    t_load = 1'b1;
                    t_val  = CW'(BUSY_CYC);
                end else if (t_last) begin
                    r_d.tmo = 1'b1;
                    r_d.st  = ST_FINISH;
                end else begin
                    t_dec = 1'b1;
                end
            end
            ST_STROBE: begin
                if (t_last) begin
                    r_d.st = ST_FINISH;
                    if (r_q.act == ACT_ACCESS) begin
                        r_d.q   = dw_q;
                        r_d.x   = dw_x;
                        r_d.res = dw_rdata;
                        if (r_q.retry && !dw_q && r_q.left != '0) begin
                            r_d.left = r_q.left - 1'b1;
                            r_d.st   = ST_GAP;
                            t_load   = 1'b1;
                            t_val    = CW'(RETRY_GAP);
                        end
                    end else begin
                        r_d.x = 1'b1;
                    end
                end else begin
                    t_dec = 1'b1;
                end
            end
            ST_GAP: begin
                if (t_last) begin
                    r_d.st = ST_STROBE;
                    t_load = 1'b1;
                    t_val  = CW'(BUSY_CYC);
                end else begin
                    t_dec = 1'b1;
                end
            end
            ST_FINISH: begin
                r_d.done     = 1'b1;
                r_d.done_par = r_q.par;
                r_d.out_res  = r_q.res;
                r_d.out_stat = '0;
                r_d.out_stat[STAT_Q]   = r_q.q;
                r_d.out_stat[STAT_X]   = r_q.x;
                r_d.out_stat[STAT_TMO] = r_q.tmo;
                r_d.out_stat[STAT_PAR] = r_q.perr;
                r_d.out_stat[STAT_VLD] = 1'b1;
                r_d.st       = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
            r_q.act <= ACT_NONE;
            r_q.inh <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign dw_busy  = (r_q.st == ST_STROBE);
    assign dw_z     = dw_busy && (r_q.act == ACT_Z);
    assign dw_c     = dw_busy && (r_q.act == ACT_C);
    assign bus_req  = (r_q.st == ST_ARB) || (r_q.st == ST_GAP) ||
                      (dw_busy && r_q.act != ACT_Z);
    assign dw_n     = r_q.n;
    assign dw_a     = r_q.a;
    assign dw_f     = r_q.f;
    assign dw_wdata = r_q.wdata;
    assign inhibit  = r_q.inh;
    assign done     = r_q.done;
    assign done_par = r_q.done_par;
    assign result   = r_q.out_res;
    assign status   = r_q.out_stat;

endmodule

// File: rtl/dataway_seq_chk.sv
module dataway_seq_chk
    import ccs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              dw_busy,
    input logic              dw_z,
    input logic              dw_c,
    input logic [4:0]        dw_n,
    input logic [4:0]        dw_f,
    input logic              done,
    input logic [STAT_W-1:0] status
);
    p_z_without_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dw_z |-> !bus_req);

    p_c_holds_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dw_c |-> bus_req);

    p_command_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_busy && $past(dw_busy)) |-> ($stable(dw_n) && $stable(dw_f)));

    p_timeout_no_q_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status[STAT_TMO]) |-> (!status[STAT_Q] && !status[STAT_X]));

    p_parity_no_x_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status[STAT_PAR]) |-> (!status[STAT_X] && !status[STAT_Q]));

    p_done_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_valid_bit_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status[STAT_VLD]);

    p_no_strobe_at_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dw_busy);

endmodule

bind dataway_seq dataway_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_req (bus_req),
    .dw_busy (dw_busy),
    .dw_z    (dw_z),
    .dw_c    (dw_c),
    .dw_n    (dw_n),
    .dw_f    (dw_f),
    .done    (done),
    .status  (status)
);

// File: tb/sim_dataway_seq.sv
`timescale 1ns/1ps
module sim_dataway_seq;
    localparam int BUSY = 3;
    localparam int GAP  = 4;
    localparam int ARBT = 6;
    localparam int MAXR = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_req = 0, ser_retry = 0, ser_perr = 0, par_req = 0;
    logic [4:0]  ser_n = 0, ser_f = 0, par_n = 0, par_f = 0;
    logic [3:0]  ser_a = 0, par_a = 0;
    logic [23:0] ser_wdata = 0, par_wdata = 0;
    logic        bus_req, bus_gnt, dw_busy, dw_z, dw_c, dw_q, dw_x;
    logic [4:0]  dw_n, dw_f;
    logic [3:0]  dw_a;
    logic [23:0] dw_wdata, dw_rdata, lam_word, mon_word, result;
    logic        inhibit, done, done_par;
    logic [4:0]  status;

    int  n_chk = 0, n_fail = 0;
    bit  gnt_en = 1;
    int  q_at = 1;
    int  att = 0, bcyc = 0, gaps = 0, arb = 0;
    bit  z_seen = 0, c_seen = 0, zreq = 0, prev_busy = 0, finished = 0;
    logic [4:0]  s_n, s_f;
    logic [3:0]  s_a;
    logic [23:0] s_wd;

    assign bus_gnt  = bus_req && gnt_en;
    assign dw_q     = (att >= q_at);
    assign dw_x     = 1'b1;
    assign dw_rdata = 24'hABCDEF;
    assign lam_word = 24'h800001;
    assign mon_word = 24'h5A3C7E;

    always #5 clk = ~clk;

    dataway_seq #(
        .BUSY_CYC (BUSY), .RETRY_GAP (GAP), .ARB_TIMEOUT (ARBT), .MAX_RETRY (MAXR)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .ser_req (ser_req), .ser_n (ser_n), .ser_a (ser_a), .ser_f (ser_f),
        .ser_wdata (ser_wdata), .ser_retry (ser_retry), .ser_perr (ser_perr),
        .par_req (par_req), .par_n (par_n), .par_a (par_a), .par_f (par_f),
        .par_wdata (par_wdata), .bus_req (bus_req), .bus_gnt (bus_gnt),
        .dw_busy (dw_busy), .dw_z (dw_z), .dw_c (dw_c), .dw_n (dw_n),
        .dw_a (dw_a), .dw_f (dw_f), .dw_wdata (dw_wdata), .dw_rdata (dw_rdata),
        .dw_q (dw_q), .dw_x (dw_x), .lam_word (lam_word), .mon_word (mon_word),
        .inhibit (inhibit), .done (done), .done_par (done_par),
        .result (result), .status (status)
    );

    typedef struct {
        string       tag;
        bit          par;
        logic [23:0] res;
        logic [4:0]  stat;
        int          att;
        int          gaps;
        int          arb;
        bit          z;
        bit          c;
        logic [4:0]  n;
        logic [3:0]  a;
        logic [4:0]  f;
        logic [23:0] wd;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: gathers dataway activity and compares each reply
    always @(negedge clk) begin
        if (rst_n) begin
            if (dw_busy && !prev_busy) begin
                att++;
                s_n = dw_n; s_a = dw_a; s_f = dw_f; s_wd = dw_wdata;
            end
            if (dw_busy) bcyc++;
            if (dw_z) z_seen = 1;
            if (dw_c) c_seen = 1;
            if (dw_z && bus_req) zreq = 1;
            if (!dw_busy && bus_req) begin
                if (att == 0) arb++;
                else gaps++;
            end
            prev_busy = dw_busy;
            if (done) begin
                if (sb.size() == 0) begin
                    chk(0, "R13 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(result == e.res, {e.tag, " result"}, result, e.res);
                    chk(status == e.stat, {e.tag, " status"}, status, e.stat);
                    chk(done_par == e.par, {"R13 R11 source ", e.tag}, done_par, e.par);
                    chk(att == e.att, {e.tag, " strobe count"}, att, e.att);
                    chk(bcyc == e.att * BUSY, {"R8 busy length ", e.tag}, bcyc, e.att * BUSY);
                    chk(gaps == e.gaps, {"R9 gap cycles ", e.tag}, gaps, e.gaps);
                    if (e.arb >= 0) chk(arb == e.arb, {"R10 arb cycles ", e.tag}, arb, e.arb);
                    chk(z_seen == e.z, {"R3 z qualifier ", e.tag}, z_seen, e.z);
                    chk(c_seen == e.c, {"R4 c qualifier ", e.tag}, c_seen, e.c);
                    chk(!zreq, {"R3 no request during z ", e.tag}, zreq, 0);
                    if (e.att > 0) begin
                        chk({s_n, s_a, s_f} == {e.n, e.a, e.f}, {"R8 command pins ", e.tag},
                            {s_n, s_a, s_f}, {e.n, e.a, e.f});
                        chk(s_wd == e.wd, {"R8 write data ", e.tag}, s_wd, e.wd);
                    end
                end
                att = 0; bcyc = 0; gaps = 0; arb = 0;
                z_seen = 0; c_seen = 0; zreq = 0;
            end
        end
    end

    function automatic exp_t mk(string tag, bit par, logic [23:0] res, logic [4:0] stat,
                                int a_cnt, int g, int ar, bit z, bit c,
                                logic [4:0] n, logic [3:0] a, logic [4:0] f, logic [23:0] wd);
        exp_t e;
        e.tag = tag; e.par = par; e.res = res; e.stat = stat; e.att = a_cnt;
        e.gaps = g; e.arb = ar; e.z = z; e.c = c; e.n = n; e.a = a; e.f = f; e.wd = wd;
        return e;
    endfunction

    task automatic wait_done(input bit par);
        do @(negedge clk); while (!(done && done_par == par));
    endtask

    // driver: one command at a time, expectation pushed first
    task automatic run(input bit par, input logic [4:0] n, input logic [3:0] a,
                       input logic [4:0] f, input logic [23:0] wd, input bit retry,
                       input bit perr, input int qa, input bit g, input exp_t e);
        @(negedge clk);
        q_at = qa; gnt_en = g;
        sb.push_back(e);
        if (par) begin
            par_n = n; par_a = a; par_f = f; par_wdata = wd; par_req = 1;
        end else begin
            ser_n = n; ser_a = a; ser_f = f; ser_wdata = wd;
            ser_retry = retry; ser_perr = perr; ser_req = 1;
        end
        wait_done(par);
        ser_req = 0; par_req = 0; ser_retry = 0; ser_perr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state, R6 inhibit starts set
        chk(done == 0 && bus_req == 0 && dw_busy == 0, "R13 reset outputs", {done, bus_req, dw_busy}, 0);
        chk(status == 0, "R13 reset status", status, 0);
        chk(inhibit == 1, "R6 reset inhibit", inhibit, 1);

        // status bits: [4]=valid [3]=parity [2]=timeout [1]=X [0]=Q
        run(0, 5'd5, 4'd2, 5'd0, 24'h0, 0, 0, 1, 1,
            mk("R1 serial read", 0, 24'hABCDEF, 5'b10011, 1, 0, 1, 0, 0, 5'd5, 4'd2, 5'd0, 24'h0));
        run(1, 5'd24, 4'd15, 5'd16, 24'h123456, 0, 0, 1, 1,
            mk("R8 local write", 1, 24'hABCDEF, 5'b10011, 1, 0, 1, 0, 0, 5'd24, 4'd15, 5'd16, 24'h123456));
        run(0, 5'd0, 4'd0, 5'd0, 24'h0, 0, 0, 1, 1,
            mk("R1 station 0", 0, 24'h0, 5'b10000, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        run(1, 5'd25, 4'd0, 5'd0, 24'h0, 0, 0, 1, 1,
            mk("R1 station 25", 1, 24'h0, 5'b10000, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        run(0, 5'd28, 4'd0, 5'd0, 24'h0, 0, 0, 1, 1,
            mk("R2 monitor", 0, 24'h5A3C7E, 5'b10010, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        run(0, 5'd28, 4'd8, 5'd26, 24'h0, 0, 0, 1, 0,
            mk("R3 initialize", 0, 24'h0, 5'b10010, 1, 0, 0, 1, 0, 5'd28, 4'd8, 5'd26, 24'h0));
        run(1, 5'd28, 4'd9, 5'd26, 24'h0, 0, 0, 1, 1,
            mk("R4 clear", 1, 24'h0, 5'b10010, 1, 0, 1, 0, 1, 5'd28, 4'd9, 5'd26, 24'h0));
        run(0, 5'd30, 4'd0, 5'd0, 24'h0, 0, 0, 1, 1,
            mk("R5 request word", 0, 24'h800001, 5'b10011, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        run(0, 5'd30, 4'd9, 5'd24, 24'h0, 0, 0, 1, 1,
            mk("R6 inhibit clear", 0, 24'h0, 5'b10010, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        chk(inhibit == 0, "R6 inhibit after clear", inhibit, 0);
        run(0, 5'd28, 4'd0, 5'd1, 24'h0, 0, 0, 1, 1,
            mk("R7 unknown at 28", 0, 24'h0, 5'b10000, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        chk(inhibit == 0, "R6 inhibit kept by other command", inhibit, 0);
        run(1, 5'd30, 4'd9, 5'd26, 24'h0, 0, 0, 1, 1,
            mk("R6 inhibit set", 1, 24'h0, 5'b10010, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        chk(inhibit == 1, "R6 inhibit after set", inhibit, 1);
        run(0, 5'd30, 4'd3, 5'd24, 24'h0, 0, 0, 1, 1,
            mk("R7 unknown at 30", 0, 24'h0, 5'b10000, 0, 0, 0, 0, 0, 0, 0, 0, 0));

        // R9 retries
        run(0, 5'd7, 4'd1, 5'd0, 24'h0, 1, 0, 3, 1,
            mk("R9 Q on third", 0, 24'hABCDEF, 5'b10011, 3, 2 * GAP, 1, 0, 0, 5'd7, 4'd1, 5'd0, 24'h0));
        run(0, 5'd7, 4'd1, 5'd0, 24'h0, 1, 0, 100, 1,
            mk("R9 retries used up", 0, 24'hABCDEF, 5'b10010, 1 + MAXR, MAXR * GAP, 1, 0, 0, 5'd7, 4'd1, 5'd0, 24'h0));
        run(0, 5'd7, 4'd1, 5'd0, 24'h0, 0, 0, 100, 1,
            mk("R9 no retry flag", 0, 24'hABCDEF, 5'b10010, 1, 0, 1, 0, 0, 5'd7, 4'd1, 5'd0, 24'h0));
        run(1, 5'd7, 4'd1, 5'd0, 24'h0, 0, 0, 100, 1,
            mk("R11 local never retries", 1, 24'hABCDEF, 5'b10010, 1, 0, 1, 0, 0, 5'd7, 4'd1, 5'd0, 24'h0));

        // R10 timeout, R12 parity
        run(0, 5'd3, 4'd0, 5'd0, 24'h0, 0, 0, 1, 0,
            mk("R10 no grant", 0, 24'h0, 5'b10100, 0, 0, ARBT, 0, 0, 0, 0, 0, 0));
        run(0, 5'd3, 4'd0, 5'd0, 24'h0, 1, 1, 1, 1,
            mk("R12 parity error", 0, 24'h0, 5'b11000, 0, 0, 0, 0, 0, 0, 0, 0, 0));

        // R11 both requests together: serial first
        @(negedge clk);
        q_at = 1; gnt_en = 1;
        sb.push_back(mk("R11 serial first", 0, 24'h5A3C7E, 5'b10010, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        sb.push_back(mk("R11 local second", 1, 24'h800001, 5'b10011, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        ser_n = 5'd28; ser_a = 0; ser_f = 0;
        par_n = 5'd30; par_a = 0; par_f = 0;
        ser_req = 1; par_req = 1;
        wait_done(0);
        ser_req = 0;
        wait_done(1);
        par_req = 0;
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R13 all replies seen", sb.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule